// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a successive-approximation analog-to-digital converter. A small register port in the style of APB lets software choose one of eight analog inputs, set a power bit and, optionally, enable an interrupt. The block then counts a programmable number of converter ticks to let the analog front end settle. It runs a binary search, most significant bit first, with a trial code sent to an external DAC and an external comparator reporting back. At the end it latches the result into a data register and flags completion.

The converter tick is a clock enable produced by dividing the bus clock by `TICK_DIV`, so everything runs in one clock domain. The divider restarts on each conversion start, which makes conversion time exact.

The sequencer has three states.

- `ST_IDLE`: nothing is running. A start moves to `ST_POWERUP`, or straight to `ST_SEARCH` when the delay is zero.
- `ST_POWERUP`: the block counts down the delay. On the last tick of the delay it moves to `ST_SEARCH`.
- `ST_SEARCH`: the block tests one bit per tick. After the LSB tick it returns to `ST_IDLE`, latching the result and setting the interrupt status.

An abort write moves `ST_POWERUP` or `ST_SEARCH` back to `ST_IDLE`.

Top module: `sar_ctrl`

## Requirements
- R1: After reset the data, status and control registers read 0, the delay register reads 8, and `irq_o`, `pwr_en_o` and `dac_code_o` are 0.
- R2: Word addresses are as follows. Offset 0x0 holds the result, with bits above RES reading 0. Offset 0x4 bit 0 is busy. Offset 0x8 is control: [2:0] channel, [3] power, [5] interrupt enable, [6] interrupt status. Offset 0xC holds the delay. The control channel and power fields drive `chan_sel_o` and `pwr_en_o`.
- R3: A control write with bit 3 set while idle starts a conversion, and status bit 0 reads 1 from the next cycle.
- R4: The delay register keeps only 6 bits. A conversion with delay D keeps busy for exactly (D+RES)*TICK_DIV cycles, counted from the start edge. D=0 skips the wait.
- R5: The search keeps a bit when `cmp_i` is 1, meaning input at or above the trial code. With an ideal comparator the data register ends equal to the input, saturated at 2^RES-1.
- R6: Interrupt status is set in the cycle busy falls. `irq_o` is high exactly when both status and enable bits are set.
- R7: Writing 0 to control clears the interrupt status, drops `pwr_en_o` and leaves the block idle.
- R8: A control write with bit 3 set while busy is ignored: the channel, the enables and the conversion timing stay unchanged.
- R9: A control write with bit 3 clear while busy aborts: busy clears at once, `dac_code_o` returns to 0, and the data register keeps its previous value.
- R10: `dac_code_o` is 0 outside the search. The first trial code, driven from the cycle after the delay ends, is 2^(RES-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits [3:2] pick the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational on `paddr` |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial code |
| dac_code_o | output | RES | Trial code to the DAC |
| chan_sel_o | output | 3 | Analog multiplexer select |
| pwr_en_o | output | 1 | Analog power enable |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong sequencer state shows up at the ports on the next tick. Either `dac_code_o` departs from the expected trial sequence, or `irq_o` rises a whole number of TICK_DIV periods away from (D+RES)*TICK_DIV. Because the bench times every conversion against that exact figure, an off-by-one in the delay counter or the bit mask gives a timing error of a full tick. A mis-kept or mis-dropped bit shows as a wrong data value for inputs chosen near powers of two and at the rails. Errors in register decode or abort handling show on the very next read or on `pwr_en_o` one cycle after the write.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_POWERUP = 2'd1,
        ST_SEARCH  = 2'd2
    } sar_state_e;

    // word index = paddr[3:2]
    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_DLY  = 2'd3;

    localparam int CH_W     = 3;
    localparam int DLY_W    = 6;
    localparam int BIT_PWR  = 3;
    localparam int BIT_IEN  = 5;
    localparam int BIT_IST  = 6;
    localparam logic [DLY_W-1:0] DLY_RESET = 6'd8;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_ctrl_pkg::*;
#(
    parameter int RES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES-1:0]   result_o,
    output logic [RES-1:0]   dac_code_o
);

    localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

    sar_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic [RES-1:0]   code_q, code_d;
    logic [RES-1:0]   mask_q, mask_d;
    logic [RES-1:0]   kept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            code_q  <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            code_q  <= code_d;
            mask_q  <= mask_d;
        end
    end

    // trial bit kept when input is at or above the trial code
    assign kept = cmp_i ? code_q : (code_q & ~mask_q);

    // next state and datapath
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        code_d   = code_q;
        mask_d   = mask_q;
        done_o   = 1'b0;
        result_o = kept;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (dly_i == '0) begin
                        state_d = ST_SEARCH;
                        code_d  = MSB;
                        mask_d  = MSB;
                    end else begin
                        state_d = ST_POWERUP;
                        cnt_d   = dly_i;
                    end
                end
            end
            ST_POWERUP: begin
                if (abort_i) begin
                    state_d = ST_IDLE;
                end else if (tick_i) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == DLY_W'(1)) begin
                        state_d = ST_SEARCH;
                        code_d  = MSB;
                        mask_d  = MSB;
                    end
                end
            end
            ST_SEARCH: begin
                if (abort_i) begin
                    state_d = ST_IDLE;
                end else if (tick_i) begin
                    if (mask_q[0]) begin
                        state_d = ST_IDLE;
                        done_o  = 1'b1;
                    end else begin
                        code_d = kept | (mask_q >> 1);
                        mask_d = mask_q >> 1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        dac_code_o = (state_q == ST_SEARCH) ? code_q : '0;
    end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int RES      = 10,
    parameter int TICK_DIV = 4,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              cmp_i,
    output logic [RES-1:0]    dac_code_o,
    output logic [CH_W-1:0]   chan_sel_o,
    output logic              pwr_en_o,
    output logic              irq_o
);

    logic [1:0]       widx;
    logic             wr_en;
    logic             wr_ctrl;
    logic             wr_dly;
    logic             busy;
    logic             done;
    logic             start;
    logic             abort;
    logic             tick;
    logic [RES-1:0]   result;

    logic [CH_W-1:0]  chan_q;
    logic             pwr_q;
    logic             ien_q;
    logic             ist_q;
    logic [DLY_W-1:0] dly_q;
    logic [RES-1:0]   data_q;

    assign widx    = paddr[3:2];
    assign wr_en   = psel && penable && pwrite;
    assign wr_ctrl = wr_en && (widx == REG_CTRL);
    assign wr_dly  = wr_en && (widx == REG_DLY);
    assign start   = wr_ctrl && pwdata[BIT_PWR] && !busy;
    assign abort   = wr_ctrl && !pwdata[BIT_PWR] && busy;

    sar_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start),
        .tick_o (tick)
    );

    sar_seq #(.RES(RES)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .start_i    (start),
        .abort_i    (abort),
        .dly_i      (dly_q),
        .cmp_i      (cmp_i),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result),
        .dac_code_o (dac_code_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            pwr_q  <= 1'b0;
            ien_q  <= 1'b0;
            ist_q  <= 1'b0;
            dly_q  <= DLY_RESET;
            data_q <= '0;
        end else begin
            if (wr_dly) begin
                dly_q <= pwdata[DLY_W-1:0];
            end
            // a start request while busy is dropped whole
            if (wr_ctrl && !(busy && pwdata[BIT_PWR])) begin
                chan_q <= pwdata[CH_W-1:0];
                pwr_q  <= pwdata[BIT_PWR];
                ien_q  <= pwdata[BIT_IEN];
                ist_q  <= ist_q & pwdata[BIT_IST];
            end
            if (done) begin
                data_q <= result;
                ist_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        prdata = '0;
        unique case (widx)
            REG_DATA: prdata[RES-1:0] = data_q;
            REG_STAT: prdata[0] = busy;
            REG_CTRL: begin
                prdata[CH_W-1:0] = chan_q;
                prdata[BIT_PWR]  = pwr_q;
                prdata[BIT_IEN]  = ien_q;
                prdata[BIT_IST]  = ist_q;
            end
            REG_DLY:  prdata[DLY_W-1:0] = dly_q;
            default:  prdata = '0;
        endcase
    end

    assign chan_sel_o = chan_q;
    assign pwr_en_o   = pwr_q;
    assign irq_o      = ist_q && ien_q;

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
    parameter int RES = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_ctrl,
    input logic [31:0]    wdata,
    input logic           busy,
    input logic           ist,
    input logic           irq,
    input logic           pwr,
    input logic [2:0]     chan,
    input logic [RES-1:0] data,
    input logic [RES-1:0] dac
);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[3] && !busy) |=> busy);

    // R8
    busy_start_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[3] && busy) |=> $stable(chan));

    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata == 32'd0) |=> (!irq && !pwr && !busy));

    // R6
    ist_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ist) |-> $fell(busy));

    // R9
    data_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data != $past(data)) |-> $fell(busy));

    // R10
    idle_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac == '0));

endmodule

bind sar_ctrl sar_ctrl_chk #(.RES(RES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (pwdata),
    .busy    (busy),
    .ist     (ist_q),
    .irq     (irq_o),
    .pwr     (pwr_en_o),
    .chan    (chan_sel_o),
    .data    (data_q),
    .dac     (dac_code_o)
);

// File: tb/sar_ctrl_tb_top.sv
module sar_ctrl_tb_top;

    localparam int RES  = 10;
    localparam int DIV  = 4;
    localparam int MAXV = (1 << RES) - 1;

    typedef struct packed {
        logic [2:0]  ch;
        logic [11:0] vin;
        logic [5:0]  dly;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 12'd0,    6'd2},
        '{3'd1, 12'd1023, 6'd1},
        '{3'd2, 12'd512,  6'd3},
        '{3'd5, 12'd511,  6'd0},
        '{3'd7, 12'd682,  6'd8},
        '{3'd4, 12'd3000, 6'd5},
        '{3'd6, 12'd1,    6'd63},
        '{3'd3, 12'd341,  6'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        cmp_i;
    logic [RES-1:0] dac_code_o;
    logic [2:0]  chan_sel_o;
    logic        pwr_en_o, irq_o;

    logic [11:0] ana [8];
    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    // behavioural comparator and multiplexer
    always_comb cmp_i = (ana[chan_sel_o] >= {2'b00, dac_code_o});

    sar_ctrl #(.RES(RES), .TICK_DIV(DIV), .ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cmp_i(cmp_i), .dac_code_o(dac_code_o), .chan_sel_o(chan_sel_o),
        .pwr_en_o(pwr_en_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // returns at the negedge right after the committing edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // waits for irq, returns cycles since t0 (or -1 on timeout)
    task automatic wait_irq(input int t0, output int dt);
        dt = -1;
        for (int i = 0; i < 400; i++) begin
            if (irq_o) begin
                dt = cyc - t0;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int t0, dt, expv;
        for (int i = 0; i < 8; i++) ana[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, r); chk("R1 data", r, 0);
        rd(4'h4, r); chk("R1 status", r, 0);
        rd(4'h8, r); chk("R1 ctrl", r, 0);
        rd(4'hC, r); chk("R1 delay", r, 8);
        chk("R1 irq", irq_o, 0);
        chk("R1 pwr", pwr_en_o, 0);
        chk("R1 dac", dac_code_o, 0);

        // R2 control layout without power: no conversion
        wr(4'h8, 32'h25);
        rd(4'h8, r); chk("R2 ctrl readback", r, 32'h25);
        chk("R2 chan_sel", chan_sel_o, 5);
        chk("R2 pwr off", pwr_en_o, 0);
        rd(4'h4, r); chk("R2 not busy", r, 0);
        // R4 delay register keeps six bits
        wr(4'hC, 32'h4F);
        rd(4'hC, r); chk("R4 delay width", r, 32'h0F);
        wr(4'h8, 32'h0);

        // vector table: R4 timing, R5 result, R6 irq, R7 clear
        foreach (VECS[k]) begin
            ana[VECS[k].ch] = VECS[k].vin;
            expv = (VECS[k].vin > MAXV) ? MAXV : VECS[k].vin;
            wr(4'hC, {26'd0, VECS[k].dly});
            wr(4'h8, 32'h28 | VECS[k].ch);
            t0 = cyc;
            chk("R2 pwr_en", pwr_en_o, 1);
            wait_irq(t0, dt);
            chk("R4 busy time", dt, (VECS[k].dly + RES) * DIV);
            rd(4'h0, r); chk("R5 result", r, expv);
            rd(4'h8, r); chk("R6 ctrl ist", r, 32'h68 | VECS[k].ch);
            rd(4'h4, r); chk("R6 not busy", r, 0);
            wr(4'h8, 32'h0);
            chk("R7 irq cleared", irq_o, 0);
            chk("R7 pwr off", pwr_en_o, 0);
            rd(4'h8, r); chk("R7 ctrl zero", r, 0);
        end

        // R3 and R10: busy and first trial code
        ana[2] = 12'd700;
        wr(4'hC, 32'd3);
        wr(4'h8, 32'h2A);
        t0 = cyc;
        rd(4'h4, r); chk("R3 busy", r, 1);
        while (cyc - t0 < 3 * DIV - 1) @(negedge clk);
        chk("R10 dac zero in powerup", dac_code_o, 0);
        @(negedge clk);
        chk("R10 first trial msb", dac_code_o, 1 << (RES - 1));
        // R8 start while busy ignored
        wr(4'h8, 32'h2D);
        chk("R8 chan kept", chan_sel_o, 2);
        wait_irq(t0, dt);
        chk("R8 timing kept", dt, (3 + RES) * DIV);
        rd(4'h0, r); chk("R8 result", r, 700);
        rd(4'h8, r); chk("R8 ctrl kept", r, 32'h6A);
        wr(4'h8, 32'h0);

        // R9 abort keeps old data
        ana[1] = 12'd300;
        wr(4'hC, 32'd2);
        wr(4'h8, 32'h29);
        t0 = cyc;
        while (cyc - t0 < 2 * DIV + 3) @(negedge clk);
        wr(4'h8, 32'h20);
        chk("R9 dac zero", dac_code_o, 0);
        rd(4'h4, r); chk("R9 busy cleared", r, 0);
        rd(4'h0, r); chk("R9 data kept", r, 700);
        repeat (20 * DIV) @(negedge clk);
        chk("R9 no late irq", irq_o, 0);
        rd(4'h0, r); chk("R9 data still kept", r, 700);

        // R6 irq gated by enable
        ana[4] = 12'd77;
        wr(4'hC, 32'd1);
        wr(4'h8, 32'h0C);
        t0 = cyc;
        repeat ((1 + RES) * DIV + 2) @(negedge clk);
        chk("R6 irq masked", irq_o, 0);
        rd(4'h8, r); chk("R6 ist set masked", r, 32'h4C);
        wr(4'h8, 32'h64);
        chk("R6 irq on enable", irq_o, 1);
        rd(4'h0, r); chk("R5 result 77", r, 77);
        wr(4'h8, 32'h0);
        chk("R7 final clear", irq_o, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule